// File: doc/BRIEF.md
# Two-Wire Sector Command Controller

This block is the bus-facing front end of a small protected byte store. It listens on a two-wire serial bus and takes one command byte per transaction. There is no slave address. The command picks a sector, either to read it or to write it. Each accepted command is followed by a password phase, in which every received byte is passed to an external password engine. That engine returns a match flag, and the flag decides whether the last password byte is acknowledged and whether the data phase is entered.

The store is 240 bytes, arranged as thirty sectors of eight bytes each, and it sits behind a byte-wide array port. A write fills an internal eight-byte staging buffer. The buffer is committed only when a stop arrives after exactly eight data bytes. The commit runs inside a self-timed busy window, and every command byte received during that window is refused. A read starts at the first byte of the addressed sector and streams bytes for as long as the master acknowledges. After the last byte of the array it continues from address zero.

SCL and the SDA input are expected to be already synchronous to `clk`. The block never drives SDA high: `sda_low` pulls the line low and is released otherwise.

Top module: `sector_cmd_ctrl`

## Requirements
- R1: A start is SDA falling while SCL is high, and a stop is SDA rising while SCL is high. Data bits are sampled on SCL rising edges, and `sda_low` changes only while SCL is low.
- R2: A command byte has bits 7:6 = 2'b10, a sector number in bits 5:1 and the direction in bit 0 (1 = read, 0 = write). A legal command is acknowledged by pulling SDA low during the ninth clock.
- R3: A command byte whose top bits are not 2'b10, or whose sector number is 30 or 31, is not acknowledged. The block then ignores the bus until the next start.
- R4: After an accepted command, eight password bytes are forwarded one by one on `pw_valid`/`pw_byte` with their index on `pw_idx`, and `pw_kind` carries the command direction. The first seven bytes are acknowledged. The eighth is acknowledged only when `pw_match` is high; otherwise the block returns to standby.
- R5: In a write, data byte i is held and then written to array address sector*8+i. The write happens only when a stop follows exactly eight acknowledged data bytes.
- R6: A write that ends with a stop after fewer or more than eight data bytes leaves the sector unchanged and does not raise `busy`.
- R7: A start received during data input aborts the write, and the sector stays unchanged.
- R8: `busy` rises on the cycle after a committing stop and stays high for WC_TICKS cycles. All array writes happen inside this window, and any command byte received while `busy` is high is not acknowledged.
- R9: A read sends bytes MSB first, starting at byte 0 of the addressed sector. Each master acknowledge moves to the next address, and address 239 is followed by address 0.
- R10: A master NACK ends a read. The block then releases SDA and drives nothing until a new start.
- R11: During reset, `sda_low`, `busy`, `arr_we` and `pw_valid` are all low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scl | input | 1 | Serial clock line, already synchronous |
| sda_in | input | 1 | Observed level of the serial data line |
| sda_low | output | 1 | Pull the data line low when 1 |
| busy | output | 1 | Write window in progress |
| pw_valid | output | 1 | One-cycle strobe for a received password byte |
| pw_idx | output | 3 | Position of that byte within the password |
| pw_byte | output | 8 | Received password byte |
| pw_kind | output | 1 | Password selector: 1 read, 0 write |
| pw_match | input | 1 | Password engine verdict, sampled at the last byte |
| arr_addr | output | 8 | Array byte address |
| arr_rdata | input | 8 | Array read data for `arr_addr` (combinational) |
| arr_wdata | output | 8 | Array write data |
| arr_we | output | 1 | Array write enable |

## Verification
The bench writes distinct contents to every sector and then reads the whole store back in one stream that runs past the end. A read pointer that fails to wrap, or that starts anywhere other than byte 0 of the sector, shows up as wrong bytes. Writes of seven and nine bytes, and a start that arrives in place of the stop, must leave the old contents in place; a loose byte-count test would overwrite them. A command sent during the busy window must be refused, and so must reserved sector numbers and a wrong last password byte. A missing guard in any of these cases shows up as a stray acknowledge or as data driven onto the line.

// File: rtl/sac_pkg.sv
// Shared types for the sector command controller.
package sac_pkg;
    // Transaction phase of the bus front end.
    typedef enum logic [2:0] {
        PH_IDLE,
        PH_CMD,
        PH_PWD,
        PH_WDAT,
        PH_RDAT
    } phase_t;
endpackage

// File: rtl/sac_line_events.sv
// Registers SCL/SDA once more and decodes edges and bus conditions.
// Assumes both inputs are already synchronous to clk.
module sac_line_events (
    input  logic clk,
    input  logic rst_n,
    input  logic scl,
    input  logic sda,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_ev,
    output logic stop_ev,
    output logic sda_now
);
    logic s_scl, s_sda, p_scl, p_sda;

    // Two-deep history of both lines; idle bus reads high.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_scl <= 1'b1; s_sda <= 1'b1; p_scl <= 1'b1; p_sda <= 1'b1;
        end else begin
            s_scl <= scl; s_sda <= sda; p_scl <= s_scl; p_sda <= s_sda;
        end
    end

    assign scl_rise = s_scl & ~p_scl;
    assign scl_fall = ~s_scl & p_scl;
    assign start_ev = s_scl & p_scl & p_sda & ~s_sda;
    assign stop_ev  = s_scl & p_scl & ~p_sda & s_sda;
    assign sda_now  = s_sda;
endmodule

// File: rtl/sac_sector_buf.sv
// Staging storage for one sector of write data, one register per slot.
// Assumes wr_idx and rd_idx stay below DEPTH.
module sac_sector_buf #(
    parameter int DEPTH = 8,
    localparam int IW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [IW-1:0] wr_idx,
    input  logic [7:0]    wr_data,
    input  logic [IW-1:0] rd_idx,
    output logic [7:0]    rd_data
);
    logic [7:0] rd_vec [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        logic [7:0] q;
        // Capture the byte addressed to this slot.
        always_ff @(posedge clk) begin
            if (!rst_n)
                q <= 8'h00;
            else if (wr_en && wr_idx == IW'(g))
                q <= wr_data;
        end
        assign rd_vec[g] = q;
    end

    assign rd_data = rd_vec[rd_idx];
endmodule

// File: rtl/sac_write_timer.sv
// Self-timed write window. A launch raises busy for WC_TICKS cycles,
// and the first NBYTES cycles of the window carry the array writes.
// Assumes WC_TICKS >= NBYTES and that no launch arrives while busy.
module sac_write_timer #(
    parameter int WC_TICKS = 64,
    parameter int NBYTES   = 8,
    localparam int CW = $clog2(WC_TICKS),
    localparam int IW = $clog2(NBYTES)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          launch,
    output logic          busy,
    output logic          commit_we,
    output logic [IW-1:0] commit_idx
);
    logic [CW-1:0] cnt;

    // Window counter: starts at launch and clears busy on the last tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
            cnt  <= '0;
        end else if (!busy) begin
            if (launch) begin
                busy <= 1'b1;
                cnt  <= '0;
            end
        end else if (cnt == CW'(WC_TICKS - 1)) begin
            busy <= 1'b0;
            cnt  <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    assign commit_we  = busy && (cnt < CW'(NBYTES));
    assign commit_idx = cnt[IW-1:0];
endmodule

// File: rtl/sector_cmd_ctrl.sv
// Two-wire sector command front end. It decodes a command byte, forwards
// password bytes, and then streams sector data to or from the array port.
// Assumes synchronous bus inputs and a combinational read on arr_rdata.
module sector_cmd_ctrl #(
    parameter int NSECT      = 30,
    parameter int SECT_BYTES = 8,
    parameter int PW_BYTES   = 8,
    parameter int WC_TICKS   = 64,
    localparam int ARR_BYTES = NSECT * SECT_BYTES,
    localparam int AW        = $clog2(ARR_BYTES),
    localparam int BIW       = $clog2(SECT_BYTES),
    localparam int PIW       = $clog2(PW_BYTES)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           scl,
    input  logic           sda_in,
    output logic           sda_low,
    output logic           busy,
    output logic           pw_valid,
    output logic [PIW-1:0] pw_idx,
    output logic [7:0]     pw_byte,
    output logic           pw_kind,
    input  logic           pw_match,
    output logic [AW-1:0]  arr_addr,
    input  logic [7:0]     arr_rdata,
    output logic [7:0]     arr_wdata,
    output logic           arr_we
);
    import sac_pkg::*;

    localparam logic [BIW:0]  WFULL = (BIW + 1)'(SECT_BYTES);
    localparam logic [AW-1:0] LAST  = AW'(ARR_BYTES - 1);

    logic scl_rise, scl_fall, start_ev, stop_ev, sda_now;
    phase_t         phase;
    logic [3:0]     bcnt;
    logic [7:0]     shreg;
    logic [4:0]     sector;
    logic           kind;
    logic [PIW-1:0] pcnt;
    logic [BIW:0]   wcnt;
    logic [AW-1:0]  rptr;
    logic           sda_low_q, pw_valid_q;
    logic           cmd_ok, ack_now, tx_bit, launch, buf_we;
    logic           commit_we;
    logic [BIW-1:0] commit_idx;
    logic [AW-1:0]  base_addr;

    sac_line_events u_ev (
        .clk(clk), .rst_n(rst_n), .scl(scl), .sda(sda_in),
        .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_ev(start_ev), .stop_ev(stop_ev), .sda_now(sda_now)
    );

    // Decisions taken from the byte just shifted in.
    assign cmd_ok    = (shreg[7:6] == 2'b10) && (32'(shreg[5:1]) < NSECT) && !busy;
    assign base_addr = AW'(sector) * AW'(SECT_BYTES);
    assign tx_bit    = arr_rdata[3'd7 - bcnt[2:0]];
    assign launch    = stop_ev && (phase == PH_WDAT) && (bcnt <= 4'd1) && (wcnt == WFULL);
    assign buf_we    = scl_rise && (phase == PH_WDAT) && (bcnt == 4'd8)
                       && sda_low_q && (wcnt < WFULL);

    // Acknowledge policy for each receiving phase.
    always_comb begin
        case (phase)
            PH_CMD:  ack_now = cmd_ok;
            PH_PWD:  ack_now = (pcnt == PIW'(PW_BYTES - 1)) ? pw_match : 1'b1;
            PH_WDAT: ack_now = 1'b1;
            default: ack_now = 1'b0;
        endcase
    end

    // Transaction sequencer: bus conditions, bit counting, phase moves.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase      <= PH_IDLE;
            bcnt       <= '0;
            shreg      <= '0;
            sector     <= '0;
            kind       <= 1'b0;
            pcnt       <= '0;
            wcnt       <= '0;
            rptr       <= '0;
            sda_low_q  <= 1'b0;
            pw_valid_q <= 1'b0;
        end else begin
            pw_valid_q <= 1'b0;
            if (start_ev && phase != PH_RDAT) begin
                phase <= PH_CMD;
                bcnt  <= '0;
            end else if (stop_ev && phase != PH_RDAT) begin
                phase <= PH_IDLE;
                bcnt  <= '0;
            end else if (scl_rise && phase != PH_IDLE) begin
                if (bcnt != 4'd8) begin
                    bcnt <= bcnt + 1'b1;
                    if (phase != PH_RDAT)
                        shreg <= {shreg[6:0], sda_now};
                    if (phase == PH_PWD && bcnt == 4'd7)
                        pw_valid_q <= 1'b1;
                end else begin
                    bcnt <= '0;
                    case (phase)
                        PH_CMD: begin
                            if (sda_low_q) begin
                                sector <= shreg[5:1];
                                kind   <= shreg[0];
                                pcnt   <= '0;
                                phase  <= PH_PWD;
                            end else begin
                                phase <= PH_IDLE;
                            end
                        end
                        PH_PWD: begin
                            if (!sda_low_q)
                                phase <= PH_IDLE;
                            else if (pcnt == PIW'(PW_BYTES - 1)) begin
                                phase <= kind ? PH_RDAT : PH_WDAT;
                                wcnt  <= '0;
                                rptr  <= base_addr;
                            end else
                                pcnt <= pcnt + 1'b1;
                        end
                        PH_WDAT: begin
                            if (wcnt <= WFULL)
                                wcnt <= wcnt + 1'b1;
                        end
                        PH_RDAT: begin
                            if (!sda_now)
                                rptr <= (rptr == LAST) ? '0 : rptr + 1'b1;
                            else
                                phase <= PH_IDLE;
                        end
                        default: phase <= PH_IDLE;
                    endcase
                end
            end
            if (scl_fall) begin
                if (phase == PH_RDAT && bcnt < 4'd8)
                    sda_low_q <= !tx_bit;
                else if ((phase == PH_CMD || phase == PH_PWD || phase == PH_WDAT)
                         && bcnt == 4'd8)
                    sda_low_q <= ack_now;
                else
                    sda_low_q <= 1'b0;
            end
        end
    end

    sac_sector_buf #(.DEPTH(SECT_BYTES)) u_buf (
        .clk(clk), .rst_n(rst_n), .wr_en(buf_we), .wr_idx(wcnt[BIW-1:0]),
        .wr_data(shreg), .rd_idx(commit_idx), .rd_data(arr_wdata)
    );

    sac_write_timer #(.WC_TICKS(WC_TICKS), .NBYTES(SECT_BYTES)) u_tmr (
        .clk(clk), .rst_n(rst_n), .launch(launch), .busy(busy),
        .commit_we(commit_we), .commit_idx(commit_idx)
    );

    assign arr_addr = busy ? base_addr + AW'(commit_idx) : rptr;
    assign arr_we   = commit_we;
    assign sda_low  = sda_low_q;
    assign pw_valid = pw_valid_q;
    assign pw_idx   = pcnt;
    assign pw_byte  = shreg;
    assign pw_kind  = kind;
endmodule

// File: rtl/sector_cmd_ctrl_chk.sv
// Temporal checks on the ports of sector_cmd_ctrl; attached with bind below.
module sector_cmd_ctrl_chk #(
    parameter int ARR_BYTES = 240,
    parameter int AW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          scl,
    input logic          sda_low,
    input logic          busy,
    input logic          pw_valid,
    input logic [AW-1:0] arr_addr,
    input logic          arr_we
);
    // R1
    sda_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (scl && $past(scl)) |-> $stable(sda_low));
    // R8
    we_in_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        arr_we |-> busy);
    // R8
    busy_refuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !sda_low);
    // R5
    commit_begin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> arr_we);
    // R4
    pw_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pw_valid |=> !pw_valid);
    // R9
    addr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        32'(arr_addr) < ARR_BYTES);
endmodule

bind sector_cmd_ctrl sector_cmd_ctrl_chk #(
    .ARR_BYTES(NSECT * SECT_BYTES),
    .AW($clog2(NSECT * SECT_BYTES))
) u_chk (
    .clk(clk), .rst_n(rst_n), .scl(scl), .sda_low(sda_low), .busy(busy),
    .pw_valid(pw_valid), .arr_addr(arr_addr), .arr_we(arr_we)
);

// File: tb/sector_cmd_ctrl_bench.sv
module sector_cmd_ctrl_bench;
    localparam int CLK_P = 10;
    localparam int WC    = 200;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl = 1'b1;
    logic sda_m = 1'b1;
    logic sda_low, busy, pw_valid, pw_kind, pw_match, arr_we;
    logic [2:0] pw_idx;
    logic [7:0] pw_byte, arr_rdata, arr_wdata, arr_addr;
    logic bus_sda;
    logic [7:0] mem [240];
    logic pw_bad;
    int total = 0;
    int bad = 0;
    int r1_viol = 0;
    logic prev_scl = 1'b1, prev_low = 1'b0;

    always #(CLK_P / 2) clk = ~clk;
    assign bus_sda = sda_m & ~sda_low;

    sector_cmd_ctrl #(.WC_TICKS(WC)) u_sector_cmd_ctrl (
        .clk(clk), .rst_n(rst_n), .scl(scl), .sda_in(bus_sda), .sda_low(sda_low),
        .busy(busy), .pw_valid(pw_valid), .pw_idx(pw_idx), .pw_byte(pw_byte),
        .pw_kind(pw_kind), .pw_match(pw_match), .arr_addr(arr_addr),
        .arr_rdata(arr_rdata), .arr_wdata(arr_wdata), .arr_we(arr_we)
    );

    function automatic logic [7:0] dval(input int s, input int i);
        return 8'((s * 8 + i) * 7 + 3);
    endfunction

    function automatic logic [7:0] pwexp(input logic k, input logic [2:0] i);
        return (k ? 8'h50 : 8'hA0) + 8'(i);
    endfunction

    // Array model with combinational read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < 240; k++) mem[k] <= 8'h00;
        end else if (arr_we) begin
            mem[arr_addr] <= arr_wdata;
        end
    end
    assign arr_rdata = mem[arr_addr];

    // Password engine model: any mismatching byte spoils the match.
    always_ff @(posedge clk) begin
        if (!rst_n) pw_bad <= 1'b1;
        else if (pw_valid)
            pw_bad <= ((pw_idx == 3'd0) ? 1'b0 : pw_bad) | (pw_byte != pwexp(pw_kind, pw_idx));
    end
    assign pw_match = !pw_bad;

    // R1 monitor: the line driver must stay put while SCL is high.
    always @(negedge clk) begin
        if (rst_n && scl && prev_scl && sda_low != prev_low) r1_viol++;
        prev_scl = scl;
        prev_low = sda_low;
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic bstart();
        sda_m = 1'b1; tick(2); scl = 1'b1; tick(3); sda_m = 1'b0; tick(3); scl = 1'b0;
    endtask

    task automatic bstop();
        sda_m = 1'b0; tick(2); scl = 1'b1; tick(3); sda_m = 1'b1; tick(3);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; tick(3); scl = 1'b1; tick(2); scl = 1'b0;
        end
        sda_m = 1'b1; tick(3); scl = 1'b1; tick(1); ack = !bus_sda; tick(1); scl = 1'b0;
    endtask

    task automatic recv_byte(output logic [7:0] b, input bit mack);
        for (int i = 7; i >= 0; i--) begin
            tick(3); scl = 1'b1; tick(1); b[i] = bus_sda; tick(1); scl = 1'b0;
        end
        sda_m = mack ? 1'b0 : 1'b1; tick(3); scl = 1'b1; tick(2); scl = 1'b0; sda_m = 1'b1;
    endtask

    task automatic cmd_pw(input logic [7:0] cmd, input bit good, output logic cack,
                          output logic last_ack, output int mid_nacks);
        logic a;
        logic [7:0] p;
        bstart();
        send_byte(cmd, cack);
        mid_nacks = 0;
        for (int i = 0; i < 8; i++) begin
            p = pwexp(cmd[0], 3'(i));
            if (i == 7 && !good) p = p ^ 8'h01;
            send_byte(p, a);
            if (i < 7 && !a) mid_nacks++;
            if (i == 7) last_ack = a;
        end
    endtask

    task automatic wait_idle();
        int n = 0;
        while (busy && n < 2000) begin tick(1); n++; end
    endtask

    task automatic read_sector_check(input int s, input string tag);
        logic c, l, a;
        int m;
        logic [7:0] b;
        cmd_pw(8'h81 | 8'(s << 1), 1'b1, c, l, m);
        chk(c && l, tag, {31'd0, l}, 1);
        for (int i = 0; i < 8; i++) begin
            recv_byte(b, i != 7);
            chk(b == dval(s, i), tag, b, dval(s, i));
        end
        bstop();
        a = 1'b0;
    endtask

    initial begin
        logic c, l, a;
        int m, n;
        logic [7:0] b;
        // R11: reset values
        tick(5);
        chk(!sda_low && !busy && !arr_we && !pw_valid, "R11 reset outputs",
            {28'd0, sda_low, busy, arr_we, pw_valid}, 0);
        rst_n = 1'b1;
        tick(4);

        // R2 R4 R5 R8: fill every sector
        for (int s = 0; s < 30; s++) begin
            cmd_pw(8'h80 | 8'(s << 1), 1'b1, c, l, m);
            chk(c, "R2 write command ack", c, 1);
            chk(l && m == 0, "R4 password acks", m, 0);
            for (int i = 0; i < 8; i++) begin
                send_byte(dval(s, i), a);
                chk(a, "R5 data byte ack", a, 1);
            end
            bstop();
            chk(busy, "R8 busy after commit", busy, 1);
            if (s == 0) begin
                n = 0;
                while (busy && n < 2000) begin tick(1); n++; end
                chk(n >= WC - 3 && n <= WC + 1, "R8 window length", n, WC - 1);
            end else if (s == 1) begin
                bstart();
                send_byte(8'h85, a);
                chk(!a, "R8 command refused while busy", a, 0);
                bstop();
                wait_idle();
            end else begin
                wait_idle();
            end
        end

        // R9: one stream over the whole array and past the end
        cmd_pw(8'h81, 1'b1, c, l, m);
        chk(c && l, "R9 read open", l, 1);
        for (int k = 0; k < 248; k++) begin
            recv_byte(b, k != 247);
            chk(b == dval((k / 8) % 30, k % 8), "R9 streamed byte", b, dval((k / 8) % 30, k % 8));
        end
        // R10: after the master NACK nothing is driven
        recv_byte(b, 1'b0);
        chk(b == 8'hFF, "R10 released after NACK", b, 8'hFF);
        bstop();

        // R9: start in the last sector and wrap to the first
        cmd_pw(8'hBB, 1'b1, c, l, m);
        chk(c && l, "R9 wrap read open", l, 1);
        for (int k = 0; k < 16; k++) begin
            recv_byte(b, k != 15);
            chk(b == dval((29 + k / 8) % 30, k % 8), "R9 wrap byte", b, dval((29 + k / 8) % 30, k % 8));
        end
        bstop();

        // R6: seven bytes then stop
        cmd_pw(8'h80 | 8'(3 << 1), 1'b1, c, l, m);
        for (int i = 0; i < 7; i++) send_byte(8'hEE, a);
        bstop();
        chk(!busy, "R6 short write no busy", busy, 0);
        // R6: nine bytes then stop
        cmd_pw(8'h80 | 8'(4 << 1), 1'b1, c, l, m);
        for (int i = 0; i < 9; i++) send_byte(8'hEE, a);
        bstop();
        chk(!busy, "R6 long write no busy", busy, 0);
        read_sector_check(3, "R6 sector 3 kept");
        read_sector_check(4, "R6 sector 4 kept");

        // R7: eight bytes, then a start instead of a stop
        cmd_pw(8'h80 | 8'(5 << 1), 1'b1, c, l, m);
        for (int i = 0; i < 8; i++) send_byte(8'hEE, a);
        bstart();
        bstop();
        chk(!busy, "R7 aborted write no busy", busy, 0);
        read_sector_check(5, "R7 sector 5 kept");

        // R3: illegal command bytes
        bstart();
        send_byte(8'hC0, a);
        chk(!a, "R3 bad top bits", a, 0);
        send_byte(8'h81, a);
        chk(!a, "R3 ignored until start", a, 0);
        bstop();
        bstart();
        send_byte(8'hBC, a);
        chk(!a, "R3 sector 30", a, 0);
        bstop();
        bstart();
        send_byte(8'hBF, a);
        chk(!a, "R3 sector 31", a, 0);
        bstop();

        // R4: wrong read password
        cmd_pw(8'h81 | 8'(2 << 1), 1'b0, c, l, m);
        chk(c && !l && m == 0, "R4 wrong read password", l, 0);
        recv_byte(b, 1'b0);
        chk(b == 8'hFF, "R4 no data after refusal", b, 8'hFF);
        bstop();
        // R4: wrong write password
        cmd_pw(8'h80 | 8'(6 << 1), 1'b0, c, l, m);
        chk(!l, "R4 wrong write password", l, 0);
        send_byte(8'h12, a);
        chk(!a, "R4 data refused", a, 0);
        bstop();
        chk(!busy, "R4 no commit", busy, 0);
        read_sector_check(6, "R4 sector 6 kept");

        // R5: overwrite a sector and read it back
        cmd_pw(8'h80 | 8'(7 << 1), 1'b1, c, l, m);
        for (int i = 0; i < 8; i++) send_byte(8'hC3 ^ 8'(i), a);
        bstop();
        wait_idle();
        cmd_pw(8'h81 | 8'(7 << 1), 1'b1, c, l, m);
        for (int i = 0; i < 8; i++) begin
            recv_byte(b, i != 7);
            chk(b == (8'hC3 ^ 8'(i)), "R5 overwrite", b, 8'hC3 ^ 8'(i));
        end
        bstop();

        chk(r1_viol == 0, "R1 line stable while SCL high", r1_viol, 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (190000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule